// File: doc/BRIEF.md
# Baseband Serial Transmit Port

This block is the MAC-side serializer that feeds frame payload bits to a baseband processor over a slow serial link. The baseband side supplies its own bit clock, which is asynchronous to the local master clock. The block samples that bit clock through a synchronizer and turns each of its rising edges into a strobe that lasts one master-clock cycle. A payload bit is moved onto the serial data output only when such a strobe coincides with the baseband's ready handshake. The handshake says that the baseband has finished its own preamble and header and now expects payload.

Software-facing logic upstream starts a frame with a pulse that carries the total number of payload bits. It then hands over payload words through a valid/ready port. Each word is sent least significant bit first. The block raises its transmit enable on the start pulse. It stops shifting once the programmed bit count has gone out, and it releases the enable a fixed tail of master clocks after the final bit. Bits left over in a partly used last word are discarded.

Top module: `bb_tx_serializer`

## Requirements
- R1: While reset is applied, `tx_en` is 0, `txd` is 0 and `word_ready` is 1.
- R2: A `start` pulse sampled while `tx_en` is 0 sets `tx_en` to 1 on that same clock edge, and loads `bit_total` as the frame length.
- R3: Payload words are sent least significant bit first, and words go out in the order they were accepted. Each qualified strobe places the next bit on `txd`, and `txd` holds that bit until the next qualified strobe.
- R4: A rising edge of `txc_in` while `tx_rdy` is 0 moves no bit. `txd` keeps its value, and the pending bit goes out on the next qualified edge.
- R5: Each rising edge of `txc_in` moves at most one bit, however long `txc_in` stays high.
- R6: After `txc_in` rises, `txd` keeps its old value through the second master-clock edge. It shows the new bit after the third edge.
- R7: Once `bit_total` bits have gone out, further `txc_in` edges leave `txd` unchanged.
- R8: `tx_en` stays 1 for two edges after the edge that put the final bit on `txd`, and is 0 after the third (tail of 3).
- R9: When `bit_total` is not a multiple of 8, the unused upper bits of the last word are dropped, and `word_ready` is 1 again after the frame ends.
- R10: A `start` pulse while `tx_en` is 1 is ignored. The running frame keeps its length and its tail timing.
- R11: `word_ready` is 0 from the edge after a word is accepted until the last bit of that word has gone out.
- R12: With `bit_total` = 0, `tx_en` is 1 for three cycles after the start edge and then 0, and `txd` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Frame start pulse |
| bit_total | input | CNT_W (16) | Number of payload bits in the frame, sampled with `start` |
| word_data | input | WORD_W (8) | Payload word |
| word_valid | input | 1 | Payload word offered |
| word_ready | output | 1 | Block can take a payload word |
| txc_in | input | 1 | Bit clock from the baseband, asynchronous |
| tx_rdy | input | 1 | Baseband expects payload bits |
| txd | output | 1 | Serial payload data |
| tx_en | output | 1 | Transmit enable held for the frame |

## Verification
A bit goes onto `txd` on the third master-clock edge after `txc_in` rises: two synchronizer stages, then the register that feeds `txd`. The monitor therefore compares each scoreboard entry one nanosecond after that third edge. When the bit changes value, it also confirms that the old value is still present after the second edge. `tx_en` is checked one edge after `start`. At the end of a frame it is checked after the second and after the third edge that follow the final shift, so a tail that is one cycle short or long is caught. `word_ready` is sampled between edges a few cycles after a word is offered, and again once the frame has closed.

// File: rtl/bbtx_pkg.sv
package bbtx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_TAIL = 2'd2
  } tx_state_e;
endpackage

// File: rtl/txc_edge_sync.sv
// Brings the asynchronous bit clock into the master domain and flags its rising edges.
module txc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txc_async,
  output logic rise_stb
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], txc_async};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= txc_async;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign rise_stb = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tx_frame_ctl.sv
// Frame sequencing: bit counter, shift qualification and enable with tail.
module tx_frame_ctl
  import bbtx_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int TAIL_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] bit_total,
  input  logic             rise_stb,
  input  logic             tx_rdy,
  input  logic             word_avail,
  output logic             shift_go,
  output logic             last_shift,
  output logic             tx_en
);
  localparam int TAIL_W = (TAIL_CYC > 1) ? $clog2(TAIL_CYC) : 1;
  localparam logic [TAIL_W-1:0] TAIL_LOAD = TAIL_W'(TAIL_CYC - 1);

  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  remain_q, remain_d;
  logic [TAIL_W-1:0] tail_q, tail_d;
  logic              en_q, en_d;

  assign shift_go   = (state_q == ST_SEND) && rise_stb && tx_rdy && word_avail;
  assign last_shift = shift_go && (remain_q == CNT_W'(1));
  assign tx_en      = en_q;

  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    tail_d   = tail_q;
    en_d     = en_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          en_d     = 1'b1;
          remain_d = bit_total;
          if (bit_total == '0) begin
            state_d = ST_TAIL;
            tail_d  = TAIL_LOAD;
          end else begin
            state_d = ST_SEND;
          end
        end
      end
      ST_SEND: begin
        if (shift_go) begin
          remain_d = remain_q - CNT_W'(1);
          if (last_shift) begin
            state_d = ST_TAIL;
            tail_d  = TAIL_LOAD;
          end
        end
      end
      ST_TAIL: begin
        if (tail_q == '0) begin
          state_d = ST_IDLE;
          en_d    = 1'b0;
        end else begin
          tail_d = tail_q - TAIL_W'(1);
        end
      end
      default: begin
        state_d = ST_IDLE;
        en_d    = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      tail_q   <= '0;
      en_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      remain_q <= remain_d;
      tail_q   <= tail_d;
      en_q     <= en_d;
    end
  end
endmodule

// File: rtl/tx_bit_shifter.sv
// One-word holding register, bit index and the serial output flop.
module tx_bit_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_in,
  input  logic              word_valid,
  output logic              word_ready,
  output logic              word_avail,
  input  logic              shift_go,
  input  logic              last_shift,
  output logic              txd
);
  localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);

  logic [WORD_W-1:0] hold_q, hold_d;
  logic              full_q, full_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              txd_q, txd_d;
  logic              load;

  assign word_ready = ~full_q;
  assign word_avail = full_q;
  assign txd        = txd_q;
  assign load       = word_valid && !full_q;

  always_comb begin
    hold_d = hold_q;
    full_d = full_q;
    idx_d  = idx_q;
    txd_d  = txd_q;
    if (shift_go) begin
      txd_d = hold_q[idx_q];
      if (last_shift || idx_q == IDX_LAST) begin
        full_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end else if (load) begin
      hold_d = word_in;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      idx_q  <= '0;
      txd_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      full_q <= full_d;
      idx_q  <= idx_d;
      txd_q  <= txd_d;
    end
  end
endmodule

// File: rtl/bb_tx_serializer.sv
module bb_tx_serializer #(
  parameter int CNT_W       = 16,
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TAIL_CYC    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  bit_total,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic              txc_in,
  input  logic              tx_rdy,
  output logic              txd,
  output logic              tx_en
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       rise_stb;
  logic       shift_go;
  logic       last_shift;
  logic       word_avail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  txc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .txc_async (txc_in),
    .rise_stb  (rise_stb)
  );

  tx_frame_ctl #(.CNT_W(CNT_W), .TAIL_CYC(TAIL_CYC)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .bit_total  (bit_total),
    .rise_stb   (rise_stb),
    .tx_rdy     (tx_rdy),
    .word_avail (word_avail),
    .shift_go   (shift_go),
    .last_shift (last_shift),
    .tx_en      (tx_en)
  );

  tx_bit_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .word_in    (word_data),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .word_avail (word_avail),
    .shift_go   (shift_go),
    .last_shift (last_shift),
    .txd        (txd)
  );
endmodule

// File: rtl/bb_tx_serializer_chk.sv
module bb_tx_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic word_valid,
  input logic word_ready,
  input logic tx_rdy,
  input logic txd,
  input logic tx_en,
  input logic shift_go
);
  // R2
  start_raises_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !tx_en) |=> tx_en);

  // R4
  shift_needs_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_go |-> (tx_rdy && tx_en));

  // R5
  single_shift_per_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_go |=> !shift_go);

  // R7
  txd_moves_on_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_go |=> $stable(txd));

  // R11
  ready_drops_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=> !word_ready);
endmodule

bind bb_tx_serializer bb_tx_serializer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start      (start),
  .word_valid (word_valid),
  .word_ready (word_ready),
  .tx_rdy     (tx_rdy),
  .txd        (txd),
  .tx_en      (tx_en),
  .shift_go   (shift_go)
);

// File: tb/bb_tx_serializer_tb.sv
`timescale 1ns/1ps
module bb_tx_serializer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] bit_total;
  logic [7:0]  word_data;
  logic        word_valid;
  logic        word_ready;
  logic        txc_in;
  logic        tx_rdy;
  logic        txd;
  logic        tx_en;

  typedef struct {
    logic  v;
    string tag;
  } exp_t;

  exp_t       sbq[$];
  logic       exp_bits[$];
  logic [7:0] feed_q[$];
  logic       cur_txd;
  logic       rdy_seen;
  int         n_chk  = 0;
  int         n_fail = 0;
  bit         done   = 0;

  always #2 clk = ~clk;

  bb_tx_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_total(bit_total),
    .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
    .txc_in(txc_in), .tx_rdy(tx_rdy), .txd(txd), .tx_en(tx_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Feeder: offers queued payload words with valid/ready.
  initial begin
    word_valid = 1'b0;
    word_data  = '0;
    rdy_seen   = 1'b0;
    forever begin
      @(negedge clk);
      if (word_valid && rdy_seen) word_valid = 1'b0;
      if (!word_valid && feed_q.size() > 0) begin
        word_data  = feed_q.pop_front();
        word_valid = 1'b1;
      end
      rdy_seen = word_ready;
    end
  end

  // Monitor: checks txd against the scoreboard three edges after each txc rise.
  logic last_v = 1'b0;
  initial begin
    forever begin
      @(posedge txc_in);
      repeat (2) @(posedge clk);
      #1;
      if (sbq.size() > 0 && sbq[0].v != last_v)
        check(txd == last_v, "R6", txd, last_v);
      @(posedge clk);
      #1;
      if (sbq.size() == 0) begin
        check(1'b0, "scoreboard empty", txd, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(txd == e.v, e.tag, txd, e.v);
        last_v = e.v;
      end
    end
  end

  task automatic begin_frame(input int total, input int seed);
    int nw;
    nw = (total + 7) / 8;
    for (int i = 0; i < nw; i++) begin
      logic [7:0] w;
      w = 8'((seed + i * 37) ^ (i << 3) ^ 8'hA5);
      feed_q.push_back(w);
      for (int b = 0; b < 8; b++)
        if (i * 8 + b < total) exp_bits.push_back(w[b]);
    end
    @(negedge clk);
    bit_total = 16'(total);
    start     = 1'b1;
    @(posedge clk);
    #1;
    check(tx_en == 1'b1, "R2", tx_en, 1);
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic push_exp(input string tag);
    if (tx_rdy && exp_bits.size() > 0) cur_txd = exp_bits.pop_front();
    sbq.push_back('{cur_txd, tag});
  endtask

  task automatic pulse(input string tag, input int high_cyc);
    @(negedge clk);
    push_exp(tag);
    txc_in = 1'b1;
    repeat (high_cyc) @(negedge clk);
    txc_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Final bit plus tail timing of tx_en.
  task automatic last_pulse(input string tag);
    @(negedge clk);
    push_exp(tag);
    txc_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(tx_en == 1'b1, "R8", tx_en, 1);
    repeat (2) @(posedge clk);
    #1;
    check(tx_en == 1'b1, "R8", tx_en, 1);
    @(posedge clk);
    #1;
    check(tx_en == 1'b0, "R8", tx_en, 0);
    @(negedge clk);
    txc_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; bit_total = '0; txc_in = 1'b0; tx_rdy = 1'b0;
    cur_txd = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(tx_en == 1'b0, "R1", tx_en, 0);
    check(txd == 1'b0, "R1", txd, 0);
    check(word_ready == 1'b1, "R1", word_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Frame A: 20 bits, partial last word.
    tx_rdy = 1'b1;
    begin_frame(20, 5);
    check(word_ready == 1'b0, "R11", word_ready, 0);
    for (int i = 0; i < 8; i++) pulse("R3", 4);
    @(negedge clk);
    tx_rdy = 1'b0;
    pulse("R4", 4);
    pulse("R4", 4);
    @(negedge clk);
    tx_rdy = 1'b1;
    pulse("R5", 20);
    pulse("R5", 4);
    // R10: a second start while busy must not restart the frame.
    @(negedge clk);
    bit_total = 16'd2;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (exp_bits.size() > 1) pulse("R10", 4);
    last_pulse("R3");
    pulse("R7", 4);
    pulse("R7", 4);
    check(word_ready == 1'b1, "R9", word_ready, 1);
    check(tx_en == 1'b0, "R7", tx_en, 0);

    // Frame B: 13 bits.
    begin_frame(13, 9);
    while (exp_bits.size() > 1) pulse("R3", 4);
    last_pulse("R9");
    check(word_ready == 1'b1, "R9", word_ready, 1);

    // Frame C: empty frame.
    @(negedge clk);
    bit_total = '0;
    start     = 1'b1;
    @(posedge clk);
    #1;
    check(tx_en == 1'b1, "R12", tx_en, 1);
    @(negedge clk);
    start = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    check(tx_en == 1'b1, "R12", tx_en, 1);
    @(posedge clk);
    #1;
    check(tx_en == 1'b0, "R12", tx_en, 0);
    pulse("R12", 4);

    repeat (10) @(negedge clk);
    check(sbq.size() == 0, "scoreboard drained", sbq.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule